// File: doc/BRIEF.md
# Reorder Buffer with Precise Exception Flush

This block sits between dispatch and the architectural register file of an out-of-order core. Dispatch claims one slot per cycle, in program order, and receives a small tag that names the slot. Execution units report results by tag, in any order, and each report may mark the instruction as having faulted. The buffer keeps the slots in a ring. It writes results to the register file only from the oldest end of the ring, strictly in program order, and it can drain up to two slots per cycle.

A faulting instruction never reaches the register file. When the oldest live slot holds a fault, the block discards that slot and every slot behind it in one cycle, including slots whose results have already arrived. It then raises a one-cycle exception request together with the program counter of the faulting instruction. Every instruction ahead of the fault has already been written back at that point, so the machine state is precise. The next allocation after a flush reuses the slot that held the fault.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `occupancy` is 0, `alloc_ready` is 1, both write enables are 0 and `exc_req` is 0.
- R2: An accepted allocation returns the current tail slot on `alloc_tag` in the same cycle. Tags count up by one per accepted allocation, wrapping modulo 16.
- R3: `alloc_ready` is 0 while 16 slots are occupied. An allocation offered while `alloc_ready` is 0 is ignored, so `occupancy` does not change.
- R4: A slot is written to the register file only after its completion has been reported and every older slot has left. Results leave in allocation order, whatever order the completions arrived in.
- R5: At most two slots retire per cycle. Port 0 carries the older slot, and port 1 is used only when port 0 is. Retirement stops at the first slot that is not complete or that carries a fault, and `occupancy` drops by the number retired.
- R6: A slot reported with the fault flag never drives a write enable. All slots older than it retire normally first.
- R7: One cycle after a faulting slot reaches the head, `exc_req` pulses high for exactly one cycle and `exc_pc` shows that slot's program counter. `exc_pc` holds that value until the next exception. At the same time all slots are discarded, `occupancy` becomes 0 and the next allocation tag equals the faulting slot's tag.
- R8: When several in-flight instructions have faulted, the oldest one is reported and only one `exc_req` pulse is produced.
- R9: A completion whose tag names a slot that holds no live, unfinished instruction has no effect. It triggers no write, no exception and no later retirement.
- R10: `alloc_ready` is 0 in the cycle in which the flush takes place, so no allocation is accepted into a buffer that is being discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Dispatch offers one instruction |
| alloc_dest | input | 5 | Destination register of the offered instruction |
| alloc_pc | input | 32 | Program counter of the offered instruction |
| alloc_ready | output | 1 | Buffer can accept an allocation this cycle |
| alloc_tag | output | 4 | Slot assigned to the offered instruction |
| cmpl_valid | input | 1 | An execution result is reported |
| cmpl_tag | input | 4 | Slot the result belongs to |
| cmpl_value | input | 32 | Result value |
| cmpl_exc | input | 1 | The instruction faulted |
| rf_we0 | output | 1 | Write enable, older retiring slot |
| rf_addr0 | output | 5 | Register address, older retiring slot |
| rf_data0 | output | 32 | Write data, older retiring slot |
| rf_we1 | output | 1 | Write enable, younger retiring slot |
| rf_addr1 | output | 5 | Register address, younger retiring slot |
| rf_data1 | output | 32 | Write data, younger retiring slot |
| exc_req | output | 1 | One-cycle exception request |
| exc_pc | output | 32 | Program counter of the faulting instruction |
| occupancy | output | 5 | Number of live slots |

## Verification
The hardest state to reach from the ports is a fault that sits behind older unfinished work, with younger slots that have already finished. The stimulus reports the faulting and younger completions first and holds back the oldest one. It then checks that nothing retires while the head is unfinished. When the head's completion is finally released, it checks that only the older results reach the register file before the flush. A second scenario reports a younger fault before an older one, which shows that ordering comes from position in the ring and not from arrival time. That scenario also catches the flush cycle itself, to see `alloc_ready` drop.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef struct packed {
    logic valid;
    logic done;
    logic exc;
  } rob_flags_t;

  // number of slots leaving this cycle, from the two retire grants
  function automatic logic [1:0] retire_count(input logic g0, input logic g1);
    return {1'b0, g0} + {1'b0, g1};
  endfunction

  // slot may be written back: present, finished, not faulted
  function automatic logic slot_clean(input rob_flags_t f);
    return f.valid && f.done && !f.exc;
  endfunction

  // slot holds a reported fault
  function automatic logic slot_faulted(input rob_flags_t f);
    return f.valid && f.done && f.exc;
  endfunction

endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_fire,
  input  logic [1:0]    ret_n,
  input  logic          flush,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic [CW-1:0] count,
  output logic          full
);

  assign full = (count == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (flush) begin
      tail  <= head;
      count <= '0;
    end else begin
      head  <= head + PW'(ret_n);
      if (alloc_fire) tail <= tail + PW'(1);
      count <= count + CW'(alloc_fire) - CW'(ret_n);
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R3

  AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_n != 2'd0 && !flush) |=> head == $past(head) + PW'($past(ret_n))); // R5

  AST_FLUSH_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tail == head && count == '0)); // R7

endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel
  import rob_pkg::*;
(
  input  rob_flags_t f0,
  input  rob_flags_t f1,
  output logic       grant0,
  output logic       grant1,
  output logic       flush,
  output logic [1:0] ret_n
);

  always_comb begin
    grant0 = slot_clean(f0);
    grant1 = grant0 && slot_clean(f1);
    flush  = slot_faulted(f0);
    ret_n  = retire_count(grant0, grant1);
  end

endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  parameter int AW    = 5,
  parameter int PCW   = 32,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc_valid,
  input  logic [AW-1:0]  alloc_dest,
  input  logic [PCW-1:0] alloc_pc,
  output logic           alloc_ready,
  output logic [PW-1:0]  alloc_tag,
  input  logic           cmpl_valid,
  input  logic [PW-1:0]  cmpl_tag,
  input  logic [DW-1:0]  cmpl_value,
  input  logic           cmpl_exc,
  output logic           rf_we0,
  output logic [AW-1:0]  rf_addr0,
  output logic [DW-1:0]  rf_data0,
  output logic           rf_we1,
  output logic [AW-1:0]  rf_addr1,
  output logic [DW-1:0]  rf_data1,
  output logic           exc_req,
  output logic [PCW-1:0] exc_pc,
  output logic [CW-1:0]  occupancy
);

  rob_flags_t     flags [DEPTH];
  logic [AW-1:0]  dest  [DEPTH];
  logic [DW-1:0]  value [DEPTH];
  logic [PCW-1:0] pcs   [DEPTH];

  logic [PW-1:0] head, tail, head1;
  logic          full, alloc_fire, cmpl_hit, flush, grant0, grant1;
  logic [1:0]    ret_n;

  assign head1       = head + PW'(1);
  assign alloc_ready = !full && !flush;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = tail;
  assign cmpl_hit    = cmpl_valid && flags[cmpl_tag].valid && !flags[cmpl_tag].done;

  rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .ret_n(ret_n),
    .flush(flush), .head(head), .tail(tail), .count(occupancy), .full(full)
  );

  rob_retire_sel u_sel (
    .f0(flags[head]), .f1(flags[head1]),
    .grant0(grant0), .grant1(grant1), .flush(flush), .ret_n(ret_n)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic at_tail, at_cmpl, leaving;
    assign at_tail = alloc_fire && (tail == PW'(i));
    assign at_cmpl = cmpl_hit && (cmpl_tag == PW'(i));
    assign leaving = (grant0 && head == PW'(i)) || (grant1 && head1 == PW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        flags[i] <= '0;
      end else if (at_tail) begin
        flags[i] <= '{valid: 1'b1, done: 1'b0, exc: 1'b0};
      end else if (leaving) begin
        flags[i] <= '0;
      end else if (at_cmpl) begin
        flags[i].done <= 1'b1;
        flags[i].exc  <= cmpl_exc;
      end
    end

    always_ff @(posedge clk) begin
      if (at_tail) begin
        dest[i] <= alloc_dest;
        pcs[i]  <= alloc_pc;
      end
      if (at_cmpl) value[i] <= cmpl_value;
    end
  end

  assign rf_we0   = grant0;
  assign rf_addr0 = dest[head];
  assign rf_data0 = value[head];
  assign rf_we1   = grant1;
  assign rf_addr1 = dest[head1];
  assign rf_data1 = value[head1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_req <= 1'b0;
      exc_pc  <= '0;
    end else begin
      exc_req <= flush;
      if (flush) exc_pc <= pcs[head];
    end
  end

  AST_NO_ALLOC_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !alloc_fire); // R3

  AST_PORT1_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we1 |-> rf_we0); // R5

  AST_FAULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !rf_we0); // R6

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occupancy == '0 && exc_req)); // R7

  AST_EXC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> !exc_req); // R7

  AST_FLUSH_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !alloc_ready); // R10

endmodule

// File: tb/rob_core_bench.sv
module rob_core_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic [4:0]  alloc_dest = '0;
  logic [31:0] alloc_pc = '0;
  logic        alloc_ready;
  logic [3:0]  alloc_tag;
  logic        cmpl_valid = 1'b0;
  logic [3:0]  cmpl_tag = '0;
  logic [31:0] cmpl_value = '0;
  logic        cmpl_exc = 1'b0;
  logic        rf_we0, rf_we1, exc_req;
  logic [4:0]  rf_addr0, rf_addr1;
  logic [31:0] rf_data0, rf_data1, exc_pc;
  logic [4:0]  occupancy;

  rob_core u_rob_core (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_dest(alloc_dest),
    .alloc_pc(alloc_pc), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag), .cmpl_value(cmpl_value),
    .cmpl_exc(cmpl_exc), .rf_we0(rf_we0), .rf_addr0(rf_addr0), .rf_data0(rf_data0),
    .rf_we1(rf_we1), .rf_addr1(rf_addr1), .rf_data1(rf_data1),
    .exc_req(exc_req), .exc_pc(exc_pc), .occupancy(occupancy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int          log_n = 0;
  logic [4:0]  log_dest [64];
  logic [31:0] log_data [64];
  int          dual_cnt = 0;
  int          exc_cnt = 0;
  logic [3:0]  exp_tail = '0;

  // retirement monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (rf_we0 && log_n < 64) begin
        log_dest[log_n] = rf_addr0; log_data[log_n] = rf_data0; log_n++;
      end
      if (rf_we1 && log_n < 64) begin
        log_dest[log_n] = rf_addr1; log_data[log_n] = rf_data1; log_n++;
      end
      if (rf_we0 && rf_we1) dual_cnt++;
      if (exc_req) exc_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic alloc(input logic [4:0] d, input logic [31:0] pc, output logic [3:0] tag);
    alloc_valid = 1'b1; alloc_dest = d; alloc_pc = pc;
    @(negedge clk);
    chk(alloc_ready == 1'b1, "R2 ready", alloc_ready, 1);
    chk(alloc_tag == exp_tail, "R2 tag", alloc_tag, exp_tail);
    tag = alloc_tag;
    exp_tail = exp_tail + 4'd1;
    @(posedge clk); #1;
    alloc_valid = 1'b0;
  endtask

  task automatic complete(input logic [3:0] tag, input logic [31:0] v, input logic e);
    cmpl_valid = 1'b1; cmpl_tag = tag; cmpl_value = v; cmpl_exc = e;
    @(posedge clk); #1;
    cmpl_valid = 1'b0; cmpl_exc = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    tick(1);
    @(negedge clk);
    chk(occupancy == 0, "R1 occupancy", occupancy, 0);
    chk(alloc_ready == 1'b1, "R1 ready", alloc_ready, 1);
    chk(!rf_we0 && !rf_we1, "R1 writes", {rf_we1, rf_we0}, 0);
    chk(exc_req == 1'b0, "R1 exc", exc_req, 0);
    tick(1);
  endtask

  task automatic t_reverse_completion();
    logic [3:0] t [3];
    int base = log_n;
    for (int i = 0; i < 3; i++) alloc(5'(i + 1), 32'h100 + 32'(4 * i), t[i]);
    complete(t[2], 32'h33, 1'b0);
    complete(t[1], 32'h22, 1'b0);
    tick(2);
    chk(log_n == base, "R4 wait for head", log_n - base, 0);
    complete(t[0], 32'h11, 1'b0);
    tick(3);
    chk(log_n == base + 3, "R4 count", log_n - base, 3);
    for (int i = 0; i < 3; i++) begin
      chk(log_dest[base + i] == 5'(i + 1), "R4 order", log_dest[base + i], i + 1);
      chk(log_data[base + i] == 32'h11 * 32'(i + 1), "R4 data", log_data[base + i], 32'h11 * (i + 1));
    end
    chk(occupancy == 0, "R4 drained", occupancy, 0);
  endtask

  task automatic t_partial_stop();
    logic [3:0] t [4];
    int base = log_n;
    int d0 = dual_cnt;
    for (int i = 0; i < 4; i++) alloc(5'(i + 4), 32'h180 + 32'(4 * i), t[i]);
    complete(t[0], 32'h40, 1'b0);
    complete(t[2], 32'h42, 1'b0);
    complete(t[3], 32'h43, 1'b0);
    tick(3);
    chk(log_n == base + 1, "R5 stop at unfinished", log_n - base, 1);
    chk(occupancy == 3, "R5 occupancy", occupancy, 3);
    complete(t[1], 32'h41, 1'b0);
    tick(3);
    chk(log_n == base + 4, "R5 count", log_n - base, 4);
    for (int i = 0; i < 4; i++)
      chk(log_dest[base + i] == 5'(i + 4), "R5 order", log_dest[base + i], i + 4);
    chk(dual_cnt == d0 + 1, "R5 dual retire", dual_cnt - d0, 1);
    chk(occupancy == 0, "R5 drained", occupancy, 0);
  endtask

  task automatic t_fault_mid();
    logic [3:0] t [4];
    logic [3:0] nt;
    int base = log_n;
    int e0 = exc_cnt;
    bit saw11 = 1'b0;
    for (int i = 0; i < 4; i++) alloc(5'(i + 8), 32'h200 + 32'(4 * i), t[i]);
    complete(t[2], 32'hC0, 1'b1);
    complete(t[3], 32'hD0, 1'b0);
    complete(t[1], 32'hB0, 1'b0);
    tick(2);
    chk(log_n == base, "R6 nothing early", log_n - base, 0);
    complete(t[0], 32'hA0, 1'b0);
    tick(4);
    chk(log_n == base + 2, "R6 older retire", log_n - base, 2);
    chk(log_dest[base] == 5'd8 && log_dest[base + 1] == 5'd9, "R6 older order",
        {log_dest[base], log_dest[base + 1]}, {5'd8, 5'd9});
    for (int i = base; i < log_n; i++) if (log_dest[i] == 5'd10 || log_dest[i] == 5'd11) saw11 = 1'b1;
    chk(!saw11, "R7 fault and younger discarded", saw11, 0);
    chk(exc_cnt == e0 + 1, "R7 one pulse", exc_cnt - e0, 1);
    chk(exc_pc == 32'h208, "R7 exc_pc", exc_pc, 32'h208);
    chk(occupancy == 0, "R7 flushed", occupancy, 0);
    exp_tail = t[2];
    alloc(5'd12, 32'h240, nt);
    chk(nt == t[2], "R7 tail reset", nt, t[2]);
    complete(nt, 32'hE0, 1'b0);
    tick(2);
    chk(log_n == base + 3 && log_dest[base + 2] == 5'd12, "R7 resume", log_n - base, 3);
    chk(exc_pc == 32'h208, "R7 exc_pc held", exc_pc, 32'h208);
  endtask

  task automatic t_oldest_first();
    logic [3:0] ta, tb;
    int base = log_n;
    int e0 = exc_cnt;
    alloc(5'd13, 32'h300, ta);
    alloc(5'd14, 32'h304, tb);
    complete(tb, 32'h1, 1'b1);
    complete(ta, 32'h2, 1'b1);
    @(negedge clk);
    chk(alloc_ready == 1'b0, "R10 ready low in flush", alloc_ready, 0);
    tick(3);
    chk(exc_cnt == e0 + 1, "R8 single pulse", exc_cnt - e0, 1);
    chk(exc_pc == 32'h300, "R8 oldest pc", exc_pc, 32'h300);
    chk(log_n == base, "R8 no retire", log_n - base, 0);
    exp_tail = ta;
  endtask

  task automatic t_full();
    logic [3:0] t [16];
    int base = log_n;
    for (int i = 0; i < 16; i++) alloc(5'(i), 32'h400 + 32'(4 * i), t[i]);
    @(negedge clk);
    chk(occupancy == 16, "R3 full count", occupancy, 16);
    chk(alloc_ready == 1'b0, "R3 ready low", alloc_ready, 0);
    alloc_valid = 1'b1; alloc_dest = 5'd31; alloc_pc = 32'hDEAD;
    tick(1);
    alloc_valid = 1'b0;
    @(negedge clk);
    chk(occupancy == 16, "R3 ignored alloc", occupancy, 16);
    for (int i = 15; i >= 0; i--) complete(t[i], 32'h500 + 32'(i), 1'b0);
    tick(10);
    chk(log_n == base + 16, "R3 drain count", log_n - base, 16);
    for (int i = 0; i < 16; i++)
      chk(log_data[base + i] == 32'h500 + 32'(i), "R4 wrap order", log_data[base + i], 32'h500 + i);
    chk(occupancy == 0, "R3 drained", occupancy, 0);
  endtask

  task automatic t_stale();
    logic [3:0] t;
    int base = log_n;
    int e0 = exc_cnt;
    complete(exp_tail, 32'h77, 1'b1);
    alloc(5'd20, 32'h600, t);
    tick(3);
    chk(log_n == base, "R9 stale ignored", log_n - base, 0);
    chk(exc_cnt == e0, "R9 no exception", exc_cnt - e0, 0);
    chk(occupancy == 1, "R9 still pending", occupancy, 1);
    complete(t, 32'h78, 1'b0);
    tick(2);
    chk(log_n == base + 1 && log_data[base] == 32'h78, "R9 real result", log_data[base], 32'h78);
  endtask

  initial begin
    tick(3);
    t_reset();
    t_reverse_completion();
    t_partial_stop();
    t_fault_mid();
    t_oldest_first();
    t_full();
    t_stale();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule